// File: doc/BRIEF.md
# Auto-Restart Fault Supervisor

This block supervises a switched-mode power controller and decides when the controller may run, when it must stop, and how it comes back. It takes comparator flags that are already synchronized to the system clock. These flags report the supply level against the turn-on and turn-off thresholds, supply overvoltage, junction overtemperature, feedback above its regulation range, and two thresholds on the soft-start/timer node. From these flags it drives the voltage reference enable, the high-voltage startup cell enable, the global switching enable, a request to release the timer-node clamp, and a one-cycle discharge pulse for the soft-start capacitor.

Supply undervoltage lockout works with hysteresis. Once the controller is running, three fault paths can send it into a latched auto-restart state. The first is an overvoltage that counts only while the timer node is low or the feedback is high. The second is overtemperature. Both of these must persist for a spike-blanking time before they count. The third is overload, timed by the external capacitor, which charges once the clamp is released. In the latched state the reference and switching stay off. The block waits for the supply to decay below the off threshold, recharges it through the startup cell, and then starts afresh at the on threshold.

Top module: `fault_supervisor`

## Requirements
- R1: After reset the startup cell is enabled. The reference, switching, clamp release and discharge outputs are all low.
- R2: While off, a supply-above-on flag sampled at a clock edge turns the block on at that edge: reference and switching go high and the startup cell goes low.
- R3: While running with neither supply flag set, the block stays on (hysteresis between the two thresholds).
- R4: While running, a supply-below-off flag turns the block off at that edge: the startup cell goes high, and reference and switching go low. The discharge output is high for exactly one cycle.
- R5: A supply-below-off flag while already off has no effect: no discharge pulse is issued and the block stays off.
- R6: An overvoltage flag has no effect while the timer-node-low flag and the feedback-high flag are both low.
- R7: A qualified overvoltage held for BLANK_CYC consecutive sampled cycles (400 at 50 MHz for 8.0 µs) enters auto-restart at the last of those edges. A run of BLANK_CYC-1 cycles followed by a low cycle does not, and the count restarts.
- R8: Overtemperature uses the same blanking as R7.
- R9: While running, clamp release follows the feedback-high flag one cycle later. It is low whenever the block is not running.
- R10: Timer-above-window entered while the clamp is released enters auto-restart at the next edge. The same flag with the clamp not released is ignored.
- R11: In auto-restart the reference, switching and startup cell are all low and stay low until supply-below-off. Then the block goes off with the startup cell high and one discharge pulse.
- R12: After an auto-restart cycle, supply-above-on restarts normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_on | input | 1 | Supply above turn-on threshold |
| vcc_below_off | input | 1 | Supply below turn-off threshold |
| vcc_over | input | 1 | Supply above overvoltage threshold |
| temp_over | input | 1 | Junction above thermal limit |
| fb_high | input | 1 | Feedback above regulation range |
| tnode_low | input | 1 | Timer node below soft-start end level |
| tnode_window | input | 1 | Timer node above blanking-window end level |
| ref_en | output | 1 | Voltage reference enable |
| startup_en | output | 1 | High-voltage startup cell enable |
| switch_en | output | 1 | Global switching enable |
| clamp_release | output | 1 | Release of the timer-node clamp |
| ss_discharge | output | 1 | One-cycle soft-start discharge pulse |

## Verification
The bench aims at the blanking edge. A fault held one cycle short of the window and then dropped must not trip, and the following full run must trip exactly at its last edge. A counter that is off by one, or one that fails to restart, would trip early, trip late or accumulate across gaps. It also drives overvoltage with both gating flags low; a design missing the gating would latch a fault during normal regulation. Undervoltage while already off must give no discharge pulse, and the window threshold must be ignored while the clamp is held. A latched fault must survive until the supply drops and must then restart cleanly; a design that unlatches early would turn the reference back on.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } fsup_state_e;
endpackage

// File: rtl/fsup_blank.sv
module fsup_blank #(
  parameter int unsigned BLANK_CYC = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic flt_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || !flt_i) begin
      cnt_d = '0;
    end else if (cnt_q != LAST) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign trip_o = en_i && flt_i && (cnt_q == LAST);

  // R7
  blank_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_i) |=> (cnt_q == '0));
  // R8
  blank_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_o && cnt_q != '0) |-> $past(flt_i));
endmodule

// File: rtl/fsup_window.sv
module fsup_window (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic fb_high_i,
  input  logic tnode_window_i,
  output logic clamp_release_o,
  output logic trip_o
);
  logic rel_q, rel_d;

  always_comb rel_d = run_i && fb_high_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_q <= 1'b0;
    else        rel_q <= rel_d;
  end

  assign clamp_release_o = rel_q;
  assign trip_o          = run_i && rel_q && tnode_window_i;

  // R9
  clamp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_release_o |-> $past(fb_high_i));
endmodule

// File: rtl/fsup_uvlo.sv
module fsup_uvlo
  import fsup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_on_i,
  input  logic vcc_off_i,
  input  logic fault_i,
  output logic run_o,
  output logic ref_en_o,
  output logic startup_en_o,
  output logic switch_en_o,
  output logic discharge_o
);
  fsup_state_e state_q, state_d;
  logic dis_q, dis_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (vcc_on_i) state_d = ST_RUN;
      ST_RUN: begin
        if (vcc_off_i)    state_d = ST_OFF;
        else if (fault_i) state_d = ST_FAULT;
      end
      ST_FAULT: if (vcc_off_i) state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
    dis_d = (state_q != ST_OFF) && vcc_off_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      dis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dis_q   <= dis_d;
    end
  end

  assign run_o        = (state_q == ST_RUN);
  assign ref_en_o     = (state_q == ST_RUN);
  assign switch_en_o  = (state_q == ST_RUN);
  assign startup_en_o = (state_q == ST_OFF);
  assign discharge_o  = dis_q;

  // R2
  turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_en_o && vcc_on_i) |=> (ref_en_o && !startup_en_o));
  // R4
  turn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_en_o && vcc_off_i) |=> (startup_en_o && discharge_o));
  // R5
  off_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startup_en_o |=> !discharge_o);
  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en_o && !startup_en_o && !vcc_off_i) |=> (!ref_en_o && !startup_en_o));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned BLANK_NS = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_above_on,
  input  logic vcc_below_off,
  input  logic vcc_over,
  input  logic temp_over,
  input  logic fb_high,
  input  logic tnode_low,
  input  logic tnode_window,
  output logic ref_en,
  output logic startup_en,
  output logic switch_en,
  output logic clamp_release,
  output logic ss_discharge
);
  localparam longint unsigned BLANK_PROD = longint'(CLK_HZ) * longint'(BLANK_NS);
  localparam int unsigned BLANK_CYC = int'(BLANK_PROD / 64'd1_000_000_000);
  localparam int unsigned N_BLANKED = 2;

  logic                 run;
  logic [N_BLANKED-1:0] blank_in;
  logic [N_BLANKED-1:0] blank_trip;
  logic                 ol_trip;
  logic                 any_fault;

  // index 0: gated overvoltage, index 1: overtemperature
  assign blank_in[0] = vcc_over && (tnode_low || fb_high);
  assign blank_in[1] = temp_over;

  for (genvar gi = 0; gi < N_BLANKED; gi++) begin : g_blank
    fsup_blank #(.BLANK_CYC(BLANK_CYC)) i_blank (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (run),
      .flt_i  (blank_in[gi]),
      .trip_o (blank_trip[gi])
    );
  end

  fsup_window i_window (
    .clk             (clk),
    .rst_n           (rst_n),
    .run_i           (run),
    .fb_high_i       (fb_high),
    .tnode_window_i  (tnode_window),
    .clamp_release_o (clamp_release),
    .trip_o          (ol_trip)
  );

  assign any_fault = (|blank_trip) || ol_trip;

  fsup_uvlo i_uvlo (
    .clk          (clk),
    .rst_n        (rst_n),
    .vcc_on_i     (vcc_above_on),
    .vcc_off_i    (vcc_below_off),
    .fault_i      (any_fault),
    .run_o        (run),
    .ref_en_o     (ref_en),
    .startup_en_o (startup_en),
    .switch_en_o  (switch_en),
    .discharge_o  (ss_discharge)
  );

  // R10
  overload_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_en && clamp_release && tnode_window && !vcc_below_off) |=> (!ref_en && !startup_en));
  // R6
  ovp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_trip[0]) |-> (tnode_low || fb_high));
endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int BLANK = 400; // 8.0 us at 50 MHz

  logic clk = 1'b0;
  logic rst_n;
  logic vcc_above_on, vcc_below_off, vcc_over, temp_over;
  logic fb_high, tnode_low, tnode_window;
  logic ref_en, startup_en, switch_en, clamp_release, ss_discharge;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_supervisor i_fault_supervisor (
    .clk(clk), .rst_n(rst_n),
    .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
    .vcc_over(vcc_over), .temp_over(temp_over), .fb_high(fb_high),
    .tnode_low(tnode_low), .tnode_window(tnode_window),
    .ref_en(ref_en), .startup_en(startup_en), .switch_en(switch_en),
    .clamp_release(clamp_release), .ss_discharge(ss_discharge)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input logic r, input logic s);
    chk(req, "ref_en", ref_en, r);
    chk(req, "switch_en", switch_en, r);
    chk(req, "startup_en", startup_en, s);
  endtask

  task automatic quiet();
    vcc_above_on = 0; vcc_below_off = 0; vcc_over = 0; temp_over = 0;
    fb_high = 0; tnode_low = 0; tnode_window = 0;
  endtask

  task automatic power_up();
    vcc_above_on = 1; tick(1); vcc_above_on = 0;
  endtask

  task automatic power_down();
    vcc_below_off = 1; tick(1); vcc_below_off = 0;
  endtask

  task automatic t_reset();
    chk_mode("R1", 1'b0, 1'b1);
    chk("R1", "clamp_release", clamp_release, 1'b0);
    chk("R1", "ss_discharge", ss_discharge, 1'b0);
  endtask

  task automatic t_on_and_hold();
    power_up();
    chk_mode("R2", 1'b1, 1'b0);
    tick(20);
    chk_mode("R3", 1'b1, 1'b0);
  endtask

  task automatic t_power_down();
    vcc_below_off = 1; tick(1); vcc_below_off = 0;
    chk_mode("R4", 1'b0, 1'b1);
    chk("R4", "ss_discharge first", ss_discharge, 1'b1);
    tick(1);
    chk("R4", "ss_discharge second", ss_discharge, 1'b0);
  endtask

  task automatic t_off_ignore();
    vcc_below_off = 1; tick(3);
    chk("R5", "ss_discharge", ss_discharge, 1'b0);
    chk_mode("R5", 1'b0, 1'b1);
    vcc_below_off = 0; tick(1);
    chk("R5", "ss_discharge after", ss_discharge, 1'b0);
  endtask

  task automatic t_ovp_gated();
    power_up();
    vcc_over = 1; tick(BLANK + 50);
    chk_mode("R6", 1'b1, 1'b0);
    vcc_over = 0; tick(1);
  endtask

  task automatic t_ovp_blank();
    vcc_over = 1; tnode_low = 1;
    tick(BLANK - 1);
    chk_mode("R7 short run", 1'b1, 1'b0);
    vcc_over = 0; tick(1);
    chk_mode("R7 gap", 1'b1, 1'b0);
    vcc_over = 1;
    tick(BLANK - 1);
    chk_mode("R7 restart", 1'b1, 1'b0);
    tick(1);
    chk_mode("R7 trip", 1'b0, 1'b0);
    vcc_over = 0; tnode_low = 0;
    tick(5);
    chk_mode("R11 latched", 1'b0, 1'b0);
    power_down();
    chk_mode("R11 release", 1'b0, 1'b1);
    chk("R11", "ss_discharge", ss_discharge, 1'b1);
    tick(1);
    chk("R11", "ss_discharge end", ss_discharge, 1'b0);
    power_up();
    chk_mode("R12", 1'b1, 1'b0);
  endtask

  task automatic t_otp_blank();
    temp_over = 1;
    tick(BLANK - 1);
    chk_mode("R8 before", 1'b1, 1'b0);
    tick(1);
    chk_mode("R8 trip", 1'b0, 1'b0);
    temp_over = 0;
    power_down();
    power_up();
    chk_mode("R12 after otp", 1'b1, 1'b0);
  endtask

  task automatic t_clamp_overload();
    tnode_window = 1; tick(3);
    chk("R10", "clamp held", clamp_release, 1'b0);
    chk_mode("R10 ignored", 1'b1, 1'b0);
    tnode_window = 0;
    fb_high = 1; tick(1);
    chk("R9", "clamp released", clamp_release, 1'b1);
    fb_high = 0; tick(1);
    chk("R9", "clamp follows", clamp_release, 1'b0);
    fb_high = 1; tick(1);
    tnode_window = 1; tick(1);
    chk_mode("R10 trip", 1'b0, 1'b0);
    tick(1);
    chk("R9", "clamp when not running", clamp_release, 1'b0);
    fb_high = 0; tnode_window = 0;
    power_down();
    chk_mode("R11 overload release", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    quiet();
    rst_n = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_on_and_hold();
    t_power_down();
    t_off_ignore();
    t_ovp_gated();
    t_ovp_blank();
    t_otp_blank();
    t_clamp_overload();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule